// File: doc/BRIEF.md
# Single-Bit Set, Clear, Invert and Extract Unit

This block performs the four single-bit operations of a 64-bit integer datapath. It takes a source word, a bit index and a two-bit operation select. It returns one of two things: the source word with the indexed bit forced to one, forced to zero or flipped, or the value of the indexed bit alone, zero-extended to the full word width.

A single index decoder turns the index into a one-hot mask, and all four operations share it. The bit index may come from a register or from an immediate field. The choice between them is made before this block, so both forms give the same result for the same index value. Only the index bits needed to address a bit position take part, so any index wraps modulo the word width.

The unit is purely combinational. It sits in the execute stage between the operand multiplexers and the result bus.

Top module: `bit_manip_unit`

## Requirements
- R1: For any index, the internal mask has exactly one bit set, at position index modulo 64. With a zero source and the set operation, the result is therefore the single bit 1 shifted left by that position.
- R2: With op_i = 2'b00 (set), result_o equals src_i with bit (index mod 64) forced to 1.
- R3: With op_i = 2'b01 (clear), result_o equals src_i with bit (index mod 64) forced to 0.
- R4: With op_i = 2'b10 (invert), result_o equals src_i with bit (index mod 64) complemented.
- R5: With op_i = 2'b11 (extract), result_o bit 0 equals src_i bit (index mod 64), and result_o bits 63..1 are all zero.
- R6: Index bits 63..6 have no effect: two indices with equal low six bits give identical results for every operation.
- R7: For set, clear and invert, every result bit other than the indexed one equals the matching source bit.
- R8: The result depends only on the present inputs, with no clock latency: a change on any input shows on result_o within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Source operand word |
| idx_i | input | 64 | Bit index; only the value modulo 64 is used |
| op_i | input | 2 | Operation: 00 set, 01 clear, 10 invert, 11 extract |
| result_o | output | 64 | Modified word, or the extracted bit zero-extended |

## Verification
The only internal state is the decoded mask. A wrong mask shows at once at result_o, in the same evaluation: bits change away from the addressed position, the addressed bit stays untouched, or extract returns a neighbouring bit. Because the block holds no state, no fault can hide for later cycles. Every vector exposes any mask or selection error that its source and index can reveal. Random sources and indices, plus directed cases at positions 0 and 63 and at indices above 63, reach every bit position for every operation.

// File: rtl/bit_manip_pkg.sv
package bit_manip_pkg;

    localparam int WORD_W = 64;
    localparam int POS_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        BOP_SET     = 2'b00,
        BOP_CLEAR   = 2'b01,
        BOP_INVERT  = 2'b10,
        BOP_EXTRACT = 2'b11
    } bit_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] mask;
    } bit_operands_t;

    function automatic bit_op_e to_bit_op(input logic [1:0] raw);
        return bit_op_e'(raw);
    endfunction

    function automatic logic is_word_op(input bit_op_e op);
        return op != BOP_EXTRACT;
    endfunction

endpackage

// File: rtl/bit_mask_decoder.sv
module bit_mask_decoder #(
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  pos_i,
    output logic [DATA_W-1:0] mask_o
);

    for (genvar g = 0; g < DATA_W; g++) begin : g_dec
        assign mask_o[g] = (pos_i == IDX_W'(g));
    end

    always_comb begin
        p_onehot_mask_r1: assert ($countones(mask_o) == 1)
            else $error("mask not one-hot for position %0d", pos_i);
    end

endmodule

// File: rtl/bit_word_modify.sv
module bit_word_modify
    import bit_manip_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  bit_op_e           op_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] word_o
);

    always_comb begin
        case (op_i)
            BOP_SET:    word_o = word_i | mask_i;
            BOP_CLEAR:  word_o = word_i & ~mask_i;
            BOP_INVERT: word_o = word_i ^ mask_i;
            default:    word_o = word_i;
        endcase
    end

    always_comb begin
        if (is_word_op(op_i)) begin
            p_others_kept_r7: assert (((word_o ^ word_i) & ~mask_i) == '0)
                else $error("unaddressed bits changed");
        end
        if (op_i == BOP_SET) begin
            p_set_hits_r2: assert ((word_o & mask_i) == mask_i)
                else $error("set left addressed bit low");
        end
        if (op_i == BOP_CLEAR) begin
            p_clear_hits_r3: assert ((word_o & mask_i) == '0)
                else $error("clear left addressed bit high");
        end
        if (op_i == BOP_INVERT) begin
            p_invert_hits_r4: assert ((word_o & mask_i) == (~word_i & mask_i))
                else $error("invert did not flip addressed bit");
        end
    end

endmodule

// File: rtl/bit_extract.sv
module bit_extract #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] word_o
);

    logic picked;

    assign picked = |(word_i & mask_i);
    assign word_o = {{(DATA_W-1){1'b0}}, picked};

endmodule

// File: rtl/bit_manip_unit.sv
module bit_manip_unit
    import bit_manip_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] idx_i,
    input  logic [1:0]        op_i,
    output logic [DATA_W-1:0] result_o
);

    bit_op_e           op;
    logic [IDX_W-1:0]  pos;
    bit_operands_t     opnd;
    logic [DATA_W-1:0] mod_word;
    logic [DATA_W-1:0] ext_word;

    assign op  = to_bit_op(op_i);
    // R6: the index wraps modulo the word width
    assign pos = IDX_W'(idx_i % DATA_W);

    assign opnd.word = src_i;

    bit_mask_decoder #(.DATA_W(DATA_W)) u_dec (
        .pos_i  (pos),
        .mask_o (opnd.mask)
    );

    bit_word_modify #(.DATA_W(DATA_W)) u_mod (
        .op_i   (op),
        .word_i (opnd.word),
        .mask_i (opnd.mask),
        .word_o (mod_word)
    );

    bit_extract #(.DATA_W(DATA_W)) u_ext (
        .word_i (opnd.word),
        .mask_i (opnd.mask),
        .word_o (ext_word)
    );

    assign result_o = is_word_op(op) ? mod_word : ext_word;

    always_comb begin
        if (op == BOP_EXTRACT) begin
            p_extract_upper_zero_r5: assert (result_o[DATA_W-1:1] == '0)
                else $error("extract result has upper bits set");
            p_extract_bit_r5: assert (result_o[0] == src_i[pos])
                else $error("extract returned wrong bit");
        end
    end

endmodule

// File: tb/bit_manip_unit_test.sv
module bit_manip_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src;
    logic [63:0] idx;
    logic [1:0]  op;
    logic [63:0] res;
    int          n_checks = 0;
    int          n_errors = 0;
    int          cycles   = 0;
    bit          done     = 1'b0;

    always #2.5 clk = ~clk;

    bit_manip_unit uut (
        .src_i    (src),
        .idx_i    (idx),
        .op_i     (op),
        .result_o (res)
    );

    function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] x,
                                         input logic [1:0] o);
        logic [63:0] m;
        int k;
        k = int'(x % 64);
        m = '0;
        for (int i = 0; i < 64; i++) if (i == k) m[i] = 1'b1;
        case (o)
            2'b00: return s | m;
            2'b01: return s & ~m;
            2'b10: return s ^ m;
            default: return {63'd0, |(s & m)};
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h (src=%h idx=%h op=%0d)",
                     req, got, exp, src, idx, op);
        end
    endtask

    function automatic string tag_of(input logic [1:0] o);
        case (o)
            2'b00: return "R2/R7";
            2'b01: return "R3/R7";
            2'b10: return "R4/R7";
            default: return "R5";
        endcase
    endfunction

    task automatic apply(input logic [63:0] s, input logic [63:0] x, input logic [1:0] o);
        @(negedge clk);
        src = s; idx = x; op = o;
        #1;
        check(tag_of(o), res, model(s, x, o));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        logic [63:0] r0, r1;
        void'($urandom(32'd20240611));
        src = '0; idx = '0; op = 2'b00;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        // initial state: zero source, set at index 0
        check("R1", res, 64'd1);

        // R1: set on zero source gives a lone bit at each position
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            src = '0; idx = 64'(i); op = 2'b00;
            #1;
            check("R1", res, 64'd1 << i);
        end

        // directed corners at both ends of the word
        for (int o = 0; o < 4; o++) begin
            apply(64'h0, 64'd0,  2'(o));
            apply(64'h0, 64'd63, 2'(o));
            apply('1,    64'd0,  2'(o));
            apply('1,    64'd63, 2'(o));
            apply(64'hA5A5_5A5A_0F0F_F0F0, 64'd64, 2'(o));
        end

        // R6: high index bits ignored, results match the low six bits
        for (int n = 0; n < 200; n++) begin
            logic [1:0]  o;
            logic [63:0] s, hi;
            s  = {$urandom, $urandom};
            hi = {$urandom, $urandom};
            o  = 2'($urandom);
            @(negedge clk);
            src = s; idx = {58'd0, hi[5:0]}; op = o;
            #1;
            r0 = res;
            @(negedge clk);
            idx = hi;
            #1;
            r1 = res;
            check("R6", r1, r0);
        end

        // R8: result follows inputs in the same cycle without a clock edge
        @(negedge clk);
        src = 64'h0; idx = 64'd5; op = 2'b00;
        #0.5;
        check("R8", res, 64'h20);
        src = 64'hFF; op = 2'b01;
        #0.5;
        check("R8", res, 64'hDF);

        // random mix of every operation
        for (int n = 0; n < 2000; n++) begin
            logic [63:0] s, x;
            s = {$urandom, $urandom};
            x = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 64);
            apply(s, x, 2'($urandom));
        end

        done = 1'b1;
        finish_run();
    end

endmodule